// File: doc/BRIEF.md
# I2C Target Register Bank

This block answers on a two-wire serial bus as a target with one fixed 7-bit address. Behind it sits a bank of 256 byte-wide registers, indexed by an 8-bit pointer. A controller first addresses the target for writing and sends one byte, which becomes the pointer. It then issues a repeated start, addresses the target again for reading, and clocks out register contents starting at the pointer. The pointer moves on by one for every byte the controller acknowledges. It stops when the controller answers with a not-acknowledge.

Both bus lines are open-drain. The block samples SCL and SDA through two-flop synchronisers. It pulls SDA low by raising an output enable and never drives SCL. On the system side, a simple write port lets local logic fill any register at any time. The pointer is held across transactions, so a read with no new pointer byte continues from where the last read left off.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the SDA output enable is low, and it stays low while the bus is idle.
- R2: When the address byte carries the block's own address with the direction bit (bit 0 of the byte, sent last) at 0, the target pulls SDA low in the acknowledge slot. It then acknowledges the next byte and stores that byte as the register pointer.
- R3: A start or repeated start, followed by the block's own address with the direction bit at 1, is acknowledged. The register byte at the pointer is then driven on SDA, most significant bit first.
- R4: When the controller acknowledges a data byte, the pointer increases by one and the next register byte follows. The increase from 255 wraps to 0.
- R5: When the controller does not acknowledge a data byte, the target releases SDA and drives nothing more until the next start. The pointer keeps the address of the last byte sent.
- R6: An address byte that does not carry the block's address gets no acknowledge. SDA stays released until the next start.
- R7: A stop or start condition seen in the middle of a byte abandons the transfer and leaves the pointer unchanged. After a start, the next eight SCL rises form a new address byte.
- R8: The SDA output enable changes only while SCL is low, except when it is released in response to a start or stop condition.
- R9: A write on the preload port sets the addressed register to the given value, and later bus reads return that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | High pulls the data line low |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 8 | Preload register index |
| pre_data | input | 8 | Preload register value |

## Verification
The hardest situations to reach from the ports are a condition that cuts a byte short, and a read that follows no fresh pointer byte. For both, the pointer is invisible except through the next byte read out. The bench therefore fills every register with a distinct value computed from its index. It ends a multi-byte read with a not-acknowledge to leave the pointer at a known place. It then aborts a pointer write after four bits with a stop, and an address byte after three bits with a repeated start. The first byte of each later read shows whether the pointer moved. Wrap-around is reached by a read that starts two registers below the top of the bank.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_TX,
        ST_TX_ACK
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [LAST:0] scl_ff;
        logic [LAST:0] sda_ff;
        logic          scl_prev;
        logic          sda_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.scl_ff   = {s_q.scl_ff[LAST-1:0], scl_i};
        s_d.sda_ff   = {s_q.sda_ff[LAST-1:0], sda_i};
        s_d.scl_prev = s_q.scl_ff[LAST];
        s_d.sda_prev = s_q.sda_ff[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_o      = s_q.scl_ff[LAST];
    assign sda_o      = s_q.sda_ff[LAST];
    assign scl_rise_o = !s_q.scl_prev && scl_o;
    assign scl_fall_o = s_q.scl_prev && !scl_o;
    assign start_o    = s_q.scl_prev && scl_o && s_q.sda_prev && !sda_o;
    assign stop_o     = s_q.scl_prev && scl_o && !s_q.sda_prev && sda_o;
endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 8,
    parameter logic [6:0]  TARGET_ADDR = 7'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sda_oe
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] BITS = CNT_W'(DATA_W);

    typedef struct packed {
        tgt_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shreg;
        logic [ADDR_W-1:0] ptr;
        logic              oe;
        logic              rw;
        logic              ack;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        rd_addr = (r_q.state == ST_TX_ACK) ? r_q.ptr + 1'b1 : r_q.ptr;
        if (stop_ev) begin
            r_d.state = ST_IDLE;
            r_d.oe    = 1'b0;
            r_d.cnt   = '0;
        end else if (start_ev) begin
            r_d.state = ST_ADDR;
            r_d.oe    = 1'b0;
            r_d.cnt   = '0;
        end else begin
            unique case (r_q.state)
                ST_ADDR: begin
                    if (scl_rise && r_q.cnt < BITS) begin
                        r_d.shreg = {r_q.shreg[DATA_W-2:0], sda_s};
                        r_d.cnt   = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == BITS) begin
                        r_d.cnt = '0;
                        if (r_q.shreg[DATA_W-1:1] == TARGET_ADDR) begin
                            r_d.rw    = r_q.shreg[0];
                            r_d.oe    = 1'b1;
                            r_d.state = ST_ADDR_ACK;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.rw) begin
                            r_d.shreg = rd_data;
                            r_d.oe    = !rd_data[DATA_W-1];
                            r_d.state = ST_TX;
                        end else begin
                            r_d.oe    = 1'b0;
                            r_d.state = ST_SUB;
                        end
                    end
                end
                ST_SUB: begin
                    if (scl_rise && r_q.cnt < BITS) begin
                        r_d.shreg = {r_q.shreg[DATA_W-2:0], sda_s};
                        r_d.cnt   = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == BITS) begin
                        r_d.cnt   = '0;
                        r_d.ptr   = r_q.shreg[ADDR_W-1:0];
                        r_d.oe    = 1'b1;
                        r_d.state = ST_SUB_ACK;
                    end
                end
                ST_SUB_ACK: begin
                    if (scl_fall) begin
                        r_d.oe    = 1'b0;
                        r_d.state = ST_IDLE;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (r_q.cnt == BITS) begin
                            r_d.cnt   = '0;
                            r_d.oe    = 1'b0;
                            r_d.ack   = 1'b0;
                            r_d.state = ST_TX_ACK;
                        end else begin
                            r_d.oe    = !r_q.shreg[DATA_W-2];
                            r_d.shreg = {r_q.shreg[DATA_W-2:0], 1'b0};
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        r_d.ack = !sda_s;
                    end else if (scl_fall) begin
                        if (r_q.ack) begin
                            r_d.ptr   = r_q.ptr + 1'b1;
                            r_d.shreg = rd_data;
                            r_d.oe    = !rd_data[DATA_W-1];
                            r_d.state = ST_TX;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe = r_q.oe;

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE) |-> !r_q.oe);

    // R8
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.oe != $past(r_q.oe)) |-> (!$past(scl_s) || $past(start_ev || stop_ev)));

    // R7
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !stop_ev) |=> (r_q.state == ST_ADDR && r_q.cnt == '0 && !r_q.oe));

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_TX_ACK && scl_fall && r_q.ack && !start_ev && !stop_ev)
        |=> (r_q.ptr == $past(r_q.ptr) + 1'b1));

    // R5
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_TX_ACK && scl_fall && !r_q.ack && !start_ev && !stop_ev)
        |=> (!r_q.oe && $stable(r_q.ptr)));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
    parameter int         ADDR_W      = 8,
    parameter int         DATA_W      = 8,
    parameter logic [6:0] TARGET_ADDR = 7'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [DATA_W-1:0] pre_data
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    i2c_line_sync #(.STAGES(2)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    i2c_reg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
        .clk     (clk),
        .wr_en   (pre_we),
        .wr_addr (pre_addr),
        .wr_data (pre_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    i2c_tgt_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TARGET_ADDR(TARGET_ADDR)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .sda_oe   (sda_oe)
    );
endmodule

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
    localparam int Q = 8;
    localparam logic [6:0] TA = 7'h2C;
    localparam logic [15:0] VEC [4] = '{
        {8'h10, 8'd1}, {8'hFE, 8'd3}, {8'h7F, 8'd2}, {8'h00, 8'd4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1, sda_drv = 1'b1;
    logic sda_oe;
    logic pre_we = 1'b0;
    logic [7:0] pre_addr = '0, pre_data = '0;
    logic sda_line;
    int checks = 0, fails = 0, viol = 0;
    logic cond_win = 1'b0, oe_prev = 1'b0, done = 1'b0;

    always #2 clk = ~clk;
    assign sda_line = sda_drv & ~sda_oe;

    i2c_reg_target #(.TARGET_ADDR(TA)) i_i2c_reg_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_oe(sda_oe), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data)
    );

    function automatic logic [7:0] fill(input logic [7:0] a);
        return 8'(a * 8'd29 + 8'd7);
    endfunction

    // R8 monitor: enable must not move while SCL is high outside start/stop
    always @(negedge clk) begin
        if (rst_n && sda_oe != oe_prev && scl_drv && !cond_win) viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic put_bit(input logic b);
        sda_drv = b; wq(); scl_drv = 1'b1; wq(); wq(); scl_drv = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq(); b = sda_line; wq(); scl_drv = 1'b0; wq();
    endtask

    task automatic cond_start();
        cond_win = 1'b1;
        sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq(); sda_drv = 1'b0; wq(); scl_drv = 1'b0; wq();
        cond_win = 1'b0;
    endtask

    task automatic cond_stop();
        cond_win = 1'b1;
        sda_drv = 1'b0; wq(); scl_drv = 1'b1; wq(); sda_drv = 1'b1; wq(); wq();
        cond_win = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack);
    endtask

    task automatic read_from_ptr(output logic [7:0] v, output logic ack);
        cond_start();
        put_byte({TA, 1'b1}, ack);
        get_byte(1'b0, v);
        cond_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic ack, b;
        logic [7:0] v;
        int ones;
        repeat (4) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", sda_oe, 0);
        rst_n = 1'b1;
        // R9 preload every register
        for (int a = 0; a < 256; a++) begin
            pre_we = 1'b1; pre_addr = 8'(a); pre_data = fill(8'(a));
            @(posedge clk); #1;
        end
        pre_we = 1'b0;
        wq();
        chk("R1", sda_oe, 0);

        // Vector table: pointer write, repeated start, sequential read
        for (int k = 0; k < 4; k++) begin
            logic [7:0] sub;
            int n;
            sub = VEC[k][15:8];
            n = int'(VEC[k][7:0]);
            cond_start();
            put_byte({TA, 1'b0}, ack);
            chk("R2", ack, 1);
            put_byte(sub, ack);
            chk("R2", ack, 1);
            cond_start();
            put_byte({TA, 1'b1}, ack);
            chk("R3", ack, 1);
            for (int j = 0; j < n; j++) begin
                get_byte(j != n - 1, v);
                // R3 first byte, R4 later bytes including 255->0 wrap
                chk(j == 0 ? "R3" : "R4", v, fill(8'(sub + 8'(j))));
            end
            if (k == 0) begin
                // R5 nothing driven after not-acknowledge
                ones = 0;
                for (int j = 0; j < 9; j++) begin
                    get_bit(b);
                    ones += int'(b);
                end
                chk("R5", ones, 9);
            end
            cond_stop();
        end

        // R5 / R9 pointer kept at last sent byte (0x03)
        read_from_ptr(v, ack);
        chk("R5", v, fill(8'h03));

        // R6 foreign address ignored
        cond_start();
        put_byte({TA ^ 7'h01, 1'b0}, ack);
        chk("R6", ack, 0);
        ones = 0;
        for (int j = 0; j < 8; j++) begin
            get_bit(b);
            ones += int'(b);
        end
        chk("R6", ones, 8);
        cond_stop();

        // R7 stop after four bits of a pointer byte
        cond_start();
        put_byte({TA, 1'b0}, ack);
        for (int i = 7; i >= 4; i--) put_bit(v[i] ^ 1'b1);
        cond_stop();
        read_from_ptr(v, ack);
        chk("R7", v, fill(8'h03));

        // R7 repeated start three bits into an address byte
        cond_start();
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        read_from_ptr(v, ack);
        chk("R7", ack, 1);
        chk("R7", v, fill(8'h03));

        // R9 preload rewrite seen by the bus
        pre_we = 1'b1; pre_addr = 8'h03; pre_data = 8'hA5;
        @(posedge clk); #1;
        pre_we = 1'b0;
        read_from_ptr(v, ack);
        chk("R9", v, 8'hA5);

        wq();
        chk("R1", sda_oe, 0);
        chk("R8", viol, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule